// File: doc/BRIEF.md
# Texture Result Routing Crossbar

This block carries filtered texture results from a set of sampler-group sources to a set of shader-array register-write ports. By default there are four sources and three destinations. Each source presents at most one wide result word per cycle. The word is 128 bits by default: four 32-bit lanes, or four 64-bit lanes when the wide-lane option is set. Each word carries a 2-bit destination index and a batch tag. A source can target any destination. When several sources target the same destination in one cycle, that destination's own round-robin arbiter picks one of them. The losing sources see ready low and keep their word on the bus.

The destination ports have no backpressure: a register-write port takes whatever the crossbar delivers. Every destination registers the word it accepts, so the word and its batch tag appear at the output one clock after the source handshake completes. Up to three transfers can complete in the same cycle, one per destination. A word whose destination index names no existing array is consumed and discarded, and an error flag is raised.

Top module: `texroute_xbar`

## Requirements
- R1: While reset is asserted, and in the cycle after reset is released with no source valid, every `dst_valid` bit and `err_bad_dst` are low.
- R2: A word accepted from any source with destination index d (0, 1 or 2) appears on destination port d one clock after acceptance. Its payload and batch tag are unchanged, and `dst_valid[d]` is high for that cycle.
- R3: When a source is valid with a legal index and no other source targets the same destination, its `src_ready` is high in the same cycle.
- R4: When several valid sources target one destination, exactly one of them sees `src_ready` high. A source seeing ready low keeps its word, index and tag stable until it is accepted.
- R5: Each destination keeps its own rotating priority, which points at source 0 after reset. When source s wins destination d, the first candidate for d's next grant is source s+1, wrapping from 3 to 0. Four sources that keep targeting one destination are therefore served in the order 0, 1, 2, 3, 0, ...
- R6: Different destinations accept independently, so up to three words can be accepted in one cycle, one per destination.
- R7: Destination index 3 is illegal. A valid word carrying it sees `src_ready` high, reaches no destination, and causes `err_bad_dst` to be high in the following cycle.
- R8: `dst_valid[d]` is low in any cycle that follows a cycle in which destination d accepted no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | N_SRC | One bit per source: a word is offered |
| src_ready | output | N_SRC | One bit per source: the offered word is taken this cycle |
| src_dst | input | N_SRC*2 | Destination index of each source, 2 bits per source |
| src_batch | input | N_SRC*BATCH_W | Batch tag of each source |
| src_data | input | N_SRC*PAY_W | Result payload of each source |
| dst_valid | output | N_DST | One bit per destination: a word is delivered this cycle |
| dst_batch | output | N_DST*BATCH_W | Batch tag delivered to each destination |
| dst_data | output | N_DST*PAY_W | Payload delivered to each destination |
| err_bad_dst | output | 1 | High for one cycle after any valid word carried an illegal index |

## Verification
`src_ready` is combinational, so the bench reads it in the same cycle it drives a word, shortly before the rising edge. At that moment it runs its own round-robin model to predict which sources are granted. The words a destination accepts, and any illegal-index error, are due one edge later. The bench holds these predictions and compares `dst_valid`, `dst_data`, `dst_batch` and `err_bad_dst` at the next falling edge, before it drives the next word. A losing source keeps its word pending in the bench until the model grants it, so the hold rule is exercised on every contended cycle.

// File: rtl/texroute_pkg.sv
package texroute_pkg;
   // Width of the destination index carried with every source word.
   localparam int unsigned DST_IDX_W = 2;

   // Lane width chosen by the wide-lane option.
   function automatic int unsigned lane_bits(input bit wide);
      return wide ? 64 : 32;
   endfunction
endpackage

// File: rtl/texroute_rr_arb.sv
module texroute_rr_arb #(
   parameter int unsigned N  = 4,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   logic [IW-1:0] ptr_q;
   logic [IW-1:0] win_idx;
   logic          any_win;

   if (N < 2) begin : g_bad_n
      $error("texroute_rr_arb: N must be at least 2");
   end

   always_comb begin
      gnt     = '0;
      win_idx = '0;
      any_win = 1'b0;
      for (int k = 0; k < N; k++) begin
         int idx;
         idx = int'(ptr_q) + k;
         if (idx >= N) idx = idx - N;
         if (!any_win && req[idx]) begin
            any_win      = 1'b1;
            gnt[idx]     = 1'b1;
            win_idx      = IW'(idx);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (any_win) begin
         ptr_q <= (int'(win_idx) == N - 1) ? '0 : win_idx + IW'(1);
      end
   end

   // R4: at most one winner per destination
   a_r4_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   // R4: a grant only goes to a requester, and a request never goes unserved
   a_r4_grant_is_request: assert property (@(posedge clk) disable iff (!rst_n)
      ((gnt & ~req) == '0) && ((|req) == (|gnt)));

   // R5: with two or more requesters, an unchanged request set moves the grant
   a_r5_rotate: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(req) > 1) |=> ((req != $past(req)) || (gnt != $past(gnt))));
endmodule

// File: rtl/texroute_dst_lane.sv
module texroute_dst_lane #(
   parameter int unsigned N_SRC   = 4,
   parameter int unsigned DST_ID  = 0,
   parameter int unsigned DW      = 2,
   parameter int unsigned PAY_W   = 128,
   parameter int unsigned BATCH_W = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_SRC-1:0]         src_valid,
   input  logic [N_SRC*DW-1:0]      src_dst,
   input  logic [N_SRC*PAY_W-1:0]   src_data,
   input  logic [N_SRC*BATCH_W-1:0] src_batch,
   output logic [N_SRC-1:0]         gnt,
   output logic                     out_valid,
   output logic [PAY_W-1:0]         out_data,
   output logic [BATCH_W-1:0]       out_batch
);
   logic [N_SRC-1:0]   req;
   logic [PAY_W-1:0]   sel_data;
   logic [BATCH_W-1:0] sel_batch;

   for (genvar s = 0; s < N_SRC; s++) begin : g_req
      assign req[s] = src_valid[s] && (src_dst[s*DW +: DW] == DW'(DST_ID));
   end

   texroute_rr_arb #(.N(N_SRC)) u_arb (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (req),
      .gnt  (gnt)
   );

   // AND-OR select on the one-hot grant
   always_comb begin
      sel_data  = '0;
      sel_batch = '0;
      for (int s = 0; s < N_SRC; s++) begin
         sel_data  = sel_data  | ({PAY_W{gnt[s]}}   & src_data[s*PAY_W +: PAY_W]);
         sel_batch = sel_batch | ({BATCH_W{gnt[s]}} & src_batch[s*BATCH_W +: BATCH_W]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_batch <= '0;
      end else begin
         out_valid <= |gnt;
         if (|gnt) begin
            out_data  <= sel_data;
            out_batch <= sel_batch;
         end
      end
   end

   // R2: a matching request is delivered one clock later
   a_r2_deliver: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |=> out_valid);

   // R8: no request, no delivery next cycle
   a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !(|req) |=> !out_valid);
endmodule

// File: rtl/texroute_xbar.sv
module texroute_xbar #(
   parameter int unsigned N_SRC      = 4,
   parameter int unsigned N_DST      = 3,
   parameter int unsigned LANES      = 4,
   parameter bit          WIDE_LANES = 1'b0,
   parameter int unsigned BATCH_W    = 6,
   localparam int unsigned DW        = texroute_pkg::DST_IDX_W,
   localparam int unsigned LANE_W    = texroute_pkg::lane_bits(WIDE_LANES),
   localparam int unsigned PAY_W     = LANES * LANE_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_SRC-1:0]         src_valid,
   output logic [N_SRC-1:0]         src_ready,
   input  logic [N_SRC*DW-1:0]      src_dst,
   input  logic [N_SRC*BATCH_W-1:0] src_batch,
   input  logic [N_SRC*PAY_W-1:0]   src_data,
   output logic [N_DST-1:0]         dst_valid,
   output logic [N_DST*BATCH_W-1:0] dst_batch,
   output logic [N_DST*PAY_W-1:0]   dst_data,
   output logic                     err_bad_dst
);
   if (N_DST < 1 || N_DST > (1 << DW)) begin : g_bad_dst
      $error("texroute_xbar: N_DST must lie in 1..2**DW");
   end
   if (N_SRC < 2) begin : g_bad_src
      $error("texroute_xbar: N_SRC must be at least 2");
   end
   if (LANES < 1 || BATCH_W < 1) begin : g_bad_w
      $error("texroute_xbar: LANES and BATCH_W must be nonzero");
   end

   logic [N_SRC-1:0] gnt_m [N_DST];
   logic [N_SRC-1:0] bad_idx;
   logic [N_SRC-1:0] taken;

   for (genvar d = 0; d < N_DST; d++) begin : g_dst
      texroute_dst_lane #(
         .N_SRC  (N_SRC),
         .DST_ID (d),
         .DW     (DW),
         .PAY_W  (PAY_W),
         .BATCH_W(BATCH_W)
      ) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .src_valid(src_valid),
         .src_dst  (src_dst),
         .src_data (src_data),
         .src_batch(src_batch),
         .gnt      (gnt_m[d]),
         .out_valid(dst_valid[d]),
         .out_data (dst_data[d*PAY_W +: PAY_W]),
         .out_batch(dst_batch[d*BATCH_W +: BATCH_W])
      );
   end

   for (genvar s = 0; s < N_SRC; s++) begin : g_src
      assign bad_idx[s] = src_valid[s] && (int'(src_dst[s*DW +: DW]) >= N_DST);
   end

   always_comb begin
      taken = '0;
      for (int d = 0; d < N_DST; d++) taken = taken | gnt_m[d];
   end

   assign src_ready = taken | bad_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) err_bad_dst <= 1'b0;
      else        err_bad_dst <= |bad_idx;
   end

   for (genvar s = 0; s < N_SRC; s++) begin : g_chk
      // R7: an illegal index raises the error flag one cycle later
      a_r7_bad_index: assert property (@(posedge clk) disable iff (!rst_n)
         (src_valid[s] && (int'(src_dst[s*DW +: DW]) >= N_DST)) |=> err_bad_dst);

      // R4: a stalled source keeps its word, index and tag
      a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (src_valid[s] && !src_ready[s]) |=>
            (src_valid[s] && $stable(src_dst[s*DW +: DW]) &&
             $stable(src_data[s*PAY_W +: PAY_W]) &&
             $stable(src_batch[s*BATCH_W +: BATCH_W])));

      // R6: a source is taken by at most one destination
      a_r6_single_route: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0({bad_idx[s], g_col[s].col}));
   end

   for (genvar s = 0; s < N_SRC; s++) begin : g_col
      logic [N_DST-1:0] col;
      for (genvar d = 0; d < N_DST; d++) begin : g_bit
         assign col[d] = gnt_m[d][s];
      end
   end

   // R1: quiet outputs in the cycle after reset
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (dst_valid == '0 && !err_bad_dst));
endmodule

// File: tb/texroute_xbar_bench.sv
module texroute_xbar_bench;
   localparam int NS = 4;
   localparam int ND = 3;
   localparam int PW = 128;
   localparam int BW = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NS-1:0]     src_valid = '0;
   logic [NS-1:0]     src_ready;
   logic [NS*2-1:0]   src_dst = '0;
   logic [NS*BW-1:0]  src_batch = '0;
   logic [NS*PW-1:0]  src_data = '0;
   logic [ND-1:0]     dst_valid;
   logic [ND*BW-1:0]  dst_batch;
   logic [ND*PW-1:0]  dst_data;
   logic              err_bad_dst;

   texroute_xbar u_texroute_xbar (
      .clk(clk), .rst_n(rst_n),
      .src_valid(src_valid), .src_ready(src_ready),
      .src_dst(src_dst), .src_batch(src_batch), .src_data(src_data),
      .dst_valid(dst_valid), .dst_batch(dst_batch), .dst_data(dst_data),
      .err_bad_dst(err_bad_dst)
   );

   always #4 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // pending source words
   bit          pv [NS];
   int          pd [NS];
   logic [BW-1:0] pb [NS];
   logic [PW-1:0] pdat [NS];
   // model state
   int          ptr [ND];
   bit          ev [ND];
   logic [PW-1:0] edat [ND];
   logic [BW-1:0] ebat [ND];
   bit          eerr;

   task automatic check(input bit ok, input string what, input logic [PW-1:0] act, input logic [PW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   function automatic logic [PW-1:0] rnd_word();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   task automatic cycle(input int mode);
      logic [NS-1:0] er;
      @(negedge clk);
      // R2/R6/R8: outputs due one edge after acceptance
      for (int d = 0; d < ND; d++) begin
         check(dst_valid[d] == ev[d], $sformatf("R2/R6/R8 dst_valid[%0d]", d),
               PW'(dst_valid[d]), PW'(ev[d]));
         if (ev[d]) begin
            check(dst_data[d*PW +: PW] == edat[d], $sformatf("R2 dst_data[%0d]", d),
                  dst_data[d*PW +: PW], edat[d]);
            check(dst_batch[d*BW +: BW] == ebat[d], $sformatf("R2 dst_batch[%0d]", d),
                  PW'(dst_batch[d*BW +: BW]), PW'(ebat[d]));
         end
      end
      check(err_bad_dst == eerr, "R7 err_bad_dst", PW'(err_bad_dst), PW'(eerr));
      // new words only for free sources (R4 hold)
      for (int s = 0; s < NS; s++) begin
         if (!pv[s]) begin
            pb[s]   = BW'($urandom);
            pdat[s] = rnd_word();
            case (mode)
               0: begin
                  int r;
                  r = int'($urandom % 16);
                  pv[s] = ($urandom % 3) != 0;
                  pd[s] = (r == 0) ? 3 : r % 3;
               end
               1: begin pv[s] = 1'b1; pd[s] = 1; end
               2: begin pv[s] = (s < 3); pd[s] = s; end
               3: begin pv[s] = (s == 2); pd[s] = 3; end
               default: begin pv[s] = 1'b0; pd[s] = 0; end
            endcase
         end
         src_valid[s]          = pv[s];
         src_dst[s*2 +: 2]     = 2'(pd[s]);
         src_batch[s*BW +: BW] = pb[s];
         src_data[s*PW +: PW]  = pdat[s];
      end
      #2;
      // model: per-destination round robin
      er   = '0;
      eerr = 1'b0;
      for (int s = 0; s < NS; s++) if (pv[s] && pd[s] == 3) begin er[s] = 1'b1; eerr = 1'b1; end
      for (int d = 0; d < ND; d++) begin
         ev[d] = 1'b0;
         for (int k = 0; k < NS; k++) begin
            int s;
            s = (ptr[d] + k) % NS;
            if (!ev[d] && pv[s] && pd[s] == d) begin
               ev[d]   = 1'b1;
               edat[d] = pdat[s];
               ebat[d] = pb[s];
               er[s]   = 1'b1;
               ptr[d]  = (s + 1) % NS;
            end
         end
      end
      check(src_ready == er, "R3/R4/R5/R7 src_ready", PW'(src_ready), PW'(er));
      for (int s = 0; s < NS; s++) if (er[s]) pv[s] = 1'b0;
   endtask

   initial begin
      for (int s = 0; s < NS; s++) begin pv[s] = 0; pd[s] = 0; pb[s] = '0; pdat[s] = '0; end
      for (int d = 0; d < ND; d++) begin ptr[d] = 0; ev[d] = 0; edat[d] = '0; ebat[d] = '0; end
      eerr = 1'b0;
      void'($urandom(32'h5eed_7a11));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: during reset
      check(dst_valid == '0 && !err_bad_dst, "R1 outputs in reset",
            PW'({dst_valid, err_bad_dst}), '0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: cycle after release, nothing offered
      check(dst_valid == '0 && !err_bad_dst, "R1 outputs after release",
            PW'({dst_valid, err_bad_dst}), '0);
      repeat (6) cycle(1);   // R5 rotation on one destination
      repeat (4) cycle(4);
      repeat (3) cycle(2);   // R6 three parallel transfers
      repeat (2) cycle(3);   // R7 illegal index
      repeat (3) cycle(4);   // R8 idle
      repeat (3000) cycle(0);
      repeat (3) cycle(4);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule